// File: doc/BRIEF.md
# Latched Multi-Source Interrupt Controller

This block gathers one-cycle event pulses from a small set of peripherals into sticky request flags. There are four sources: an external pin event, the timer 0 overflow, the timer 1 overflow and the converter done event. Every flag captures its event whether or not that source is enabled. A request to the processor core is raised only when three things hold at once: a flag is set, its per-source enable bit is 1, and the global enable bit is 1. Every accepted request uses one fixed entry address. The handler reads the flag register to find the source, then writes zeros to clear the flags it has handled.

Taking an interrupt (acknowledge) drops the global enable, so the handler cannot be re-entered. The return-from-interrupt pulse sets the global enable again. When timer 0 runs as an external event counter, the pin event flag is held at 0.

Top module: `irqc_top`

## Requirements
- R1: After reset, every flag, every per-source enable bit and the global enable are 0, and `irq_req` is 0.
- R2: A 1 on `src_evt[i]` in a cycle sets flag i at that clock edge. The flag stays set until software clears it, even when enable bit i or the global enable is 0. Source indices: 0 = pin event, 1 = timer 0 overflow, 2 = timer 1 overflow, 3 = converter done.
- R3: A write to offset 0 (flag register, bit i = flag i) clears every flag whose data bit is 0. Flags whose data bit is 1 are left as they were.
- R4: If a source event arrives in the same cycle as a software clear of its flag, the flag is 1 after that edge.
- R5: When the global enable is 1, `irq_req` is 1 exactly when at least one flag is set together with its enable bit. Enable bits are at offset 1, bit i for source i.
- R6: While the global enable (offset 2, bit 0) is 0, `irq_req` is 0 whatever the flags and enables hold.
- R7: `irq_vec` always presents the entry address 0x0008.
- R8: A 1 on `irq_ack` clears the global enable at the next edge. A 1 on `irq_ret` sets it, unless `irq_ack` is also 1 in that cycle. Both pulses take priority over a software write to offset 2.
- R9: While `ext_count_mode` is 1, flag 0 is 0 after every edge, and pin events do not set it. Flags 1 to 3 are not affected.
- R10: Reads are combinational from `addr`. Offset 0 returns the flags, 1 the enables, 2 the global enable in bit 0. Offset 3 returns zero. Unused upper bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt | input | 4 | One-cycle event pulses, one per source |
| ext_count_mode | input | 1 | Timer 0 counts external events; blocks the pin flag |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register offset |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` |
| irq_ack | input | 1 | Core accepted the request |
| irq_ret | input | 1 | Core left the handler |
| irq_req | output | 1 | Request toward the core |
| irq_vec | output | 16 | Entry address |

## Verification
The bench builds the block with its default parameters: four sources, an 8-bit data path and a 16-bit entry address. The flag register therefore leaves four upper bits unused, and the bench can check that they read as zero. With only four sources, every source can be driven alone and in combination. The pin-event blocking, which belongs to source 0, and the clear-versus-event collision on the converter flag are both driven directly.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned SRC_N    = 4;
    localparam int unsigned REG_W    = 8;
    localparam int unsigned ADDR_W   = 2;
    localparam int unsigned VEC_W    = 16;
    localparam logic [15:0] VEC_ADDR = 16'h0008;

    // source positions inside every per-source vector
    localparam int unsigned SRC_PIN  = 0;
    localparam int unsigned SRC_TMR0 = 1;
    localparam int unsigned SRC_TMR1 = 2;
    localparam int unsigned SRC_ADC  = 3;

    // register offsets
    localparam int unsigned OFS_FLAG = 0;
    localparam int unsigned OFS_MASK = 1;
    localparam int unsigned OFS_CTRL = 2;

    typedef enum logic [1:0] {
        GIE_HOLD  = 2'd0,
        GIE_CLEAR = 2'd1,
        GIE_SET   = 2'd2,
        GIE_LOAD  = 2'd3
    } gie_op_e;

    typedef struct packed {
        gie_op_e op;
        logic    val;
    } gie_cmd_t;

    // Core pulses outrank software: acknowledge, then return, then a write.
    function automatic gie_cmd_t gie_pick(input logic ack, input logic ret,
                                          input logic sw_ld, input logic sw_val);
        gie_cmd_t c;
        c.val = sw_val;
        if (ack)        c.op = GIE_CLEAR;
        else if (ret)   c.op = GIE_SET;
        else if (sw_ld) c.op = GIE_LOAD;
        else            c.op = GIE_HOLD;
        return c;
    endfunction

    function automatic logic gie_next(input gie_cmd_t c, input logic cur);
        logic n;
        case (c.op)
            GIE_CLEAR: n = 1'b0;
            GIE_SET:   n = 1'b1;
            GIE_LOAD:  n = c.val;
            default:   n = cur;
        endcase
        return n;
    endfunction

    // A new event beats a clear; a block beats everything.
    function automatic logic flag_next(input logic cur, input logic evt,
                                       input logic clr, input logic blk);
        logic n;
        if (blk)      n = 1'b0;
        else if (evt) n = 1'b1;
        else if (clr) n = 1'b0;
        else          n = cur;
        return n;
    endfunction

endpackage

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC = SRC_N,
    parameter int unsigned PIN_IDX = SRC_PIN
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] evt,
    input  logic [NUM_SRC-1:0] clr,
    input  logic               pin_block,
    output logic [NUM_SRC-1:0] flags
);

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_flag
        logic blk;
        logic q;

        if (k == PIN_IDX) begin : g_pin
            assign blk = pin_block;
        end else begin : g_other
            assign blk = 1'b0;
        end

        always_ff @(posedge clk) begin
            if (rst) q <= 1'b0;
            else     q <= flag_next(q, evt[k], clr[k], blk);
        end

        assign flags[k] = q;
    end

endmodule

// File: rtl/irqc_regif.sv
module irqc_regif
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC = SRC_N,
    parameter int unsigned DATA_W  = REG_W,
    parameter int unsigned AW      = ADDR_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [AW-1:0]      addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NUM_SRC-1:0] flags,
    input  logic               gie,
    output logic [NUM_SRC-1:0] flag_clr,
    output logic [NUM_SRC-1:0] mask,
    output logic               sw_gie_ld,
    output logic               sw_gie_val,
    output logic [DATA_W-1:0]  rd_data
);

    localparam logic [AW-1:0] A_FLAG = AW'(OFS_FLAG);
    localparam logic [AW-1:0] A_MASK = AW'(OFS_MASK);
    localparam logic [AW-1:0] A_CTRL = AW'(OFS_CTRL);

    logic hit_flag;
    logic hit_mask;
    logic hit_ctrl;

    assign hit_flag = wr_en && (addr == A_FLAG);
    assign hit_mask = wr_en && (addr == A_MASK);
    assign hit_ctrl = wr_en && (addr == A_CTRL);

    // zeros in the written data clear, ones leave the flag alone
    assign flag_clr   = hit_flag ? ~wdata[NUM_SRC-1:0] : '0;
    assign sw_gie_ld  = hit_ctrl;
    assign sw_gie_val = wdata[0];

    always_ff @(posedge clk) begin
        if (rst)           mask <= '0;
        else if (hit_mask) mask <= wdata[NUM_SRC-1:0];
    end

    always_comb begin
        rd_data = '0;
        case (addr)
            A_FLAG:  rd_data[NUM_SRC-1:0] = flags;
            A_MASK:  rd_data[NUM_SRC-1:0] = mask;
            A_CTRL:  rd_data[0]           = gie;
            default: rd_data              = '0;
        endcase
    end

endmodule

// File: rtl/irqc_gate.sv
module irqc_gate
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC = SRC_N
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ack,
    input  logic               ret,
    input  logic               sw_ld,
    input  logic               sw_val,
    input  logic [NUM_SRC-1:0] flags,
    input  logic [NUM_SRC-1:0] mask,
    output logic               gie,
    output logic               req
);

    gie_cmd_t cmd;

    assign cmd = gie_pick(ack, ret, sw_ld, sw_val);

    always_ff @(posedge clk) begin
        if (rst) gie <= 1'b0;
        else     gie <= gie_next(cmd, gie);
    end

    assign req = gie & (|(flags & mask));

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC  = SRC_N,
    parameter int unsigned DATA_W   = REG_W,
    parameter int unsigned AW       = ADDR_W,
    parameter int unsigned VW       = VEC_W,
    parameter logic [VW-1:0] ENTRY  = VW'(VEC_ADDR),
    parameter int unsigned PIN_IDX  = SRC_PIN
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_evt,
    input  logic               ext_count_mode,
    input  logic               wr_en,
    input  logic [AW-1:0]      addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               irq_ack,
    input  logic               irq_ret,
    output logic               irq_req,
    output logic [VW-1:0]      irq_vec
);

    logic [NUM_SRC-1:0] flags;
    logic [NUM_SRC-1:0] flag_clr;
    logic [NUM_SRC-1:0] mask;
    logic               gie;
    logic               sw_gie_ld;
    logic               sw_gie_val;

    irqc_flag_bank #(.NUM_SRC(NUM_SRC), .PIN_IDX(PIN_IDX)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .evt       (src_evt),
        .clr       (flag_clr),
        .pin_block (ext_count_mode),
        .flags     (flags)
    );

    irqc_regif #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .AW(AW)) u_regif (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .flags      (flags),
        .gie        (gie),
        .flag_clr   (flag_clr),
        .mask       (mask),
        .sw_gie_ld  (sw_gie_ld),
        .sw_gie_val (sw_gie_val),
        .rd_data    (rd_data)
    );

    irqc_gate #(.NUM_SRC(NUM_SRC)) u_gate (
        .clk    (clk),
        .rst    (rst),
        .ack    (irq_ack),
        .ret    (irq_ret),
        .sw_ld  (sw_gie_ld),
        .sw_val (sw_gie_val),
        .flags  (flags),
        .mask   (mask),
        .gie    (gie),
        .req    (irq_req)
    );

    assign irq_vec = ENTRY;

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC = SRC_N,
    parameter int unsigned DATA_W  = REG_W,
    parameter int unsigned AW      = ADDR_W,
    parameter int unsigned PIN_IDX = SRC_PIN
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] src_evt,
    input logic               ext_count_mode,
    input logic               wr_en,
    input logic [AW-1:0]      addr,
    input logic [DATA_W-1:0]  wdata,
    input logic               irq_ack,
    input logic               irq_ret,
    input logic [NUM_SRC-1:0] flags,
    input logic [NUM_SRC-1:0] mask,
    input logic               gie,
    input logic               irq_req
);

    logic clr_wr;
    assign clr_wr = wr_en && (addr == AW'(OFS_FLAG));

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_bit
        logic blk;
        assign blk = (k == PIN_IDX) ? ext_count_mode : 1'b0;

        // R2 R4
        event_sets_chk: assert property (@(posedge clk) disable iff (rst)
            (src_evt[k] && !blk) |=> flags[k]);

        // R2 R3
        flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
            (flags[k] && !blk && !(clr_wr && !wdata[k])) |=> flags[k]);
    end

    // R5
    req_when_armed_chk: assert property (@(posedge clk) disable iff (rst)
        (gie && |(flags & mask)) |-> irq_req);

    // R6
    no_req_masked_chk: assert property (@(posedge clk) disable iff (rst)
        !gie |-> !irq_req);

    // R8
    ack_drops_gie_chk: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> !gie);

    // R8
    ret_sets_gie_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_ret && !irq_ack) |=> gie);

    // R9
    pin_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        ext_count_mode |=> !flags[PIN_IDX]);

endmodule

bind irqc_top irqc_chk #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .AW(AW), .PIN_IDX(PIN_IDX)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .src_evt        (src_evt),
    .ext_count_mode (ext_count_mode),
    .wr_en          (wr_en),
    .addr           (addr),
    .wdata          (wdata),
    .irq_ack        (irq_ack),
    .irq_ret        (irq_ret),
    .flags          (flags),
    .mask           (mask),
    .gie            (gie),
    .irq_req        (irq_req)
);

// File: tb/irqc_top_bench.sv
`timescale 1ns/1ps
module irqc_top_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] src_evt;
    logic       ext_count_mode;
    logic       wr_en;
    logic [1:0] addr;
    logic [7:0] wdata;
    logic [7:0] rd_data;
    logic       irq_ack;
    logic       irq_ret;
    logic       irq_req;
    logic [15:0] irq_vec;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    irqc_top u_irqc_top (
        .clk(clk), .rst(rst), .src_evt(src_evt), .ext_count_mode(ext_count_mode),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rd_data(rd_data),
        .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_req(irq_req), .irq_vec(irq_vec)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        addr = a; wr_en = 1'b0;
        #1;
        v = rd_data;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        cyc();
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic pulse(input logic [3:0] m);
        src_evt = m;
        cyc();
        src_evt = '0;
    endtask

    task automatic do_reset();
        rst = 1'b1; src_evt = '0; ext_count_mode = 1'b0; wr_en = 1'b0;
        addr = '0; wdata = '0; irq_ack = 1'b0; irq_ret = 1'b0;
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
    endtask

    task automatic t_reset();
        logic [7:0] v;
        do_reset();
        rd(2'd0, v); chk("R1 flags", v, 8'h00);
        rd(2'd1, v); chk("R1 enables", v, 8'h00);
        rd(2'd2, v); chk("R1 gie", v, 8'h00);
        chk("R1 req", irq_req, 1'b0);
        chk("R7 vector", irq_vec, 16'h0008);
        rd(2'd3, v); chk("R10 offset3", v, 8'h00);
    endtask

    task automatic t_sticky();
        logic [7:0] v;
        pulse(4'b0010);
        rd(2'd0, v); chk("R2 tmr0 flag set while disabled", v, 8'h02);
        chk("R6 no req gie off", irq_req, 1'b0);
        repeat (3) cyc();
        rd(2'd0, v); chk("R2 flag held", v, 8'h02);
        pulse(4'b1101);
        rd(2'd0, v); chk("R2 all flags", v, 8'h0F);
    endtask

    task automatic t_clear();
        logic [7:0] v;
        wr(2'd0, 8'hFA);               // clears bits 0 and 2
        rd(2'd0, v); chk("R3 partial clear", v, 8'h0A);
        wr(2'd0, 8'hFF);
        rd(2'd0, v); chk("R3 ones keep", v, 8'h0A);
        // collision on converter flag, clear everything in the same cycle
        src_evt = 4'b1000; addr = 2'd0; wdata = 8'h00; wr_en = 1'b1;
        cyc();
        src_evt = '0; wr_en = 1'b0;
        rd(2'd0, v); chk("R4 event beats clear", v, 8'h08);
    endtask

    task automatic t_gating();
        logic [7:0] v;
        wr(2'd2, 8'h01);
        rd(2'd2, v); chk("R10 gie read", v, 8'h01);
        chk("R5 no enable no req", irq_req, 1'b0);
        wr(2'd1, 8'h08);
        rd(2'd1, v); chk("R10 enable read", v, 8'h08);
        chk("R5 enabled flag req", irq_req, 1'b1);
        chk("R7 vector on req", irq_vec, 16'h0008);
        wr(2'd1, 8'h02);
        chk("R5 other enable no req", irq_req, 1'b0);
        wr(2'd1, 8'h0F);
        wr(2'd2, 8'h00);
        chk("R6 gie off no req", irq_req, 1'b0);
        wr(2'd2, 8'h01);
        chk("R5 req back", irq_req, 1'b1);
    endtask

    task automatic t_ackret();
        logic [7:0] v;
        irq_ack = 1'b1; cyc(); irq_ack = 1'b0;
        rd(2'd2, v); chk("R8 ack clears gie", v, 8'h00);
        chk("R8 req drops after ack", irq_req, 1'b0);
        rd(2'd0, v); chk("R2 flag survives ack", v, 8'h08);
        irq_ret = 1'b1; cyc(); irq_ret = 1'b0;
        rd(2'd2, v); chk("R8 ret sets gie", v, 8'h01);
        chk("R8 req after ret", irq_req, 1'b1);
        irq_ack = 1'b1; irq_ret = 1'b1; cyc(); irq_ack = 1'b0; irq_ret = 1'b0;
        rd(2'd2, v); chk("R8 ack over ret", v, 8'h00);
        irq_ret = 1'b1; addr = 2'd2; wdata = 8'h00; wr_en = 1'b1;
        cyc();
        irq_ret = 1'b0; wr_en = 1'b0;
        rd(2'd2, v); chk("R8 ret over write", v, 8'h01);
        irq_ack = 1'b1; addr = 2'd2; wdata = 8'h01; wr_en = 1'b1;
        cyc();
        irq_ack = 1'b0; wr_en = 1'b0;
        rd(2'd2, v); chk("R8 ack over write", v, 8'h00);
    endtask

    task automatic t_extmode();
        logic [7:0] v;
        wr(2'd0, 8'h00);
        pulse(4'b0001);
        rd(2'd0, v); chk("R9 pin flag set normally", v, 8'h01);
        ext_count_mode = 1'b1;
        cyc();
        rd(2'd0, v); chk("R9 pin flag forced low", v, 8'h00);
        pulse(4'b0101);
        rd(2'd0, v); chk("R9 pin ignored, tmr1 kept", v, 8'h04);
        ext_count_mode = 1'b0;
        cyc();
        rd(2'd0, v); chk("R9 no late pin flag", v, 8'h04);
    endtask

    initial begin
        t_reset();
        t_sticky();
        t_clear();
        t_gating();
        t_ackret();
        t_extmode();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule